// File: doc/BRIEF.md
# Power-of-Two Region Window Splitter

This block turns a contiguous address region into a run of address-translation windows. Each window has a power-of-two size and is naturally aligned. A caller hands over one region per request: a physical start, a bus start, a byte size, an action word and two flags. One flag restarts the window numbering from a supplied index. The other marks the final region of a batch. The engine then issues one record per window on a valid/ready output. A record carries the window number, the match address with its enable bit, the remap address, the address mask and the action word.

At each step the engine takes the biggest window that still fits in the remaining size and is aligned to the current physical start. There are eight window slots. No window may be smaller than 64 KiB. If any of the region is left over when splitting stops, the batch is marked as failed, and every later region in the same batch produces nothing. After the final region, every unused slot gets an all-zero disable record. A one-cycle done pulse closes every request and reports the next free window number and the failure flag.

A configuration sequencer uses it by sending the I/O region first and then the translated memory regions, one after another. The window number carries over from one region to the next. The sequencer turns each record into register writes.

Top module: `wsplit_top`

## Requirements
- R1: After reset, req_ready is 1, rec_valid is 0 and done is 0. The next free window number is 0 and there is no failure.
- R2: The size of each window is the smaller of two values: the largest power of two not above the remaining size, and the value of the lowest set bit of the current physical start. A physical start of zero sets no alignment limit. The size shows in rec_mask.
- R3: For a split record, rec_mask equals the complement of (size − 1) with bits 15:0 forced to 0. rec_match equals the physical start with bit 0 (the enable bit) set to 1. rec_action equals the action word of the request.
- R4: After each accepted split record, the physical start and the bus start both advance by the window size, the remaining size shrinks by the same amount, and the window number goes up by 1. rec_remap equals the current bus start.
- R5: Splitting ends when the window number reaches 8 or the remaining size reaches 0. If nothing is left over, done_win reports the next free window number (0 to 8) and done_err is 0.
- R6: If a computed window would be below 0x10000 bytes, or if the slots run out while size remains, the failure flag is set and the next free window number becomes 0. done then reports done_err=1 and done_win=0.
- R7: While the failure flag is set, a region sent with req_first=0 produces no split records.
- R8: A request with req_first=1 loads the window number from req_start_win and clears the failure flag before its region is split.
- R9: After the split records of a request with req_last=1, the block issues disable records in increasing order for windows from the next free number up to 7, starting from 0 after a failure. Each disable record has rec_match, rec_remap, rec_mask and rec_action all equal to 0.
- R10: While rec_valid is 1 and rec_ready is 0, rec_valid stays 1 and every record field holds its value.
- R11: done is high for exactly one cycle per request, after the last record of that request has been accepted. req_ready is 1 only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Region request present |
| req_ready | output | 1 | Engine idle and accepting a region |
| req_first | input | 1 | Restart numbering from req_start_win and clear the failure flag |
| req_last | input | 1 | Final region of the batch; disable the unused slots afterwards |
| req_start_win | input | 4 | Starting window number, used when req_first is 1 |
| req_phys | input | 64 | Physical start address of the region |
| req_bus | input | 64 | Bus start address of the region |
| req_size | input | 64 | Region size in bytes |
| req_action | input | 32 | Action word copied into every split record |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Record consumer ready |
| rec_win | output | 3 | Window slot number of the record |
| rec_match | output | 64 | Match address with bit 0 as the enable bit |
| rec_remap | output | 64 | Remap (bus) address |
| rec_mask | output | 64 | Address mask |
| rec_action | output | 32 | Action word |
| done | output | 1 | One-cycle end-of-request pulse |
| done_win | output | 4 | Next free window number (0 after a failure) |
| done_err | output | 1 | Failure flag of the batch |

## Verification
Suppose the window-number counter or the failure flag holds a wrong value. The error shows at the ports on the very next record: rec_win is off, or a disable sweep starts at the wrong slot. It shows at the latest on the done pulse that closes the same request. Suppose instead the sizing logic mis-picks a size. rec_mask changes on the same record, and the match and remap addresses of every later record in that region shift with it. The bench runs sweeps over many physical starts and sizes in multiples of 64 KiB, adds unaligned and slot-exhausting cases, and uses multi-region batches. Each record is compared as it is accepted, under irregular backpressure.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    parameter int unsigned ADDR_W   = 64;
    parameter int unsigned ACT_W    = 32;
    parameter int unsigned NWIN     = 8;
    parameter int unsigned MIN_LOG2 = 16;

    localparam int unsigned IDX_W = $clog2(NWIN);
    localparam int unsigned CNT_W = $clog2(NWIN + 1);
    localparam int unsigned LOG_W = $clog2(ADDR_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ACT_W-1:0]  act_t;

    localparam addr_t FLOOR_BITS = (addr_t'(1) << MIN_LOG2) - addr_t'(1);

    typedef struct packed {
        logic [IDX_W-1:0] win;
        addr_t            match;
        addr_t            remap;
        addr_t            mask;
        act_t             action;
    } wrec_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SPLIT = 2'd1,
        S_CLEAR = 2'd2,
        S_FIN   = 2'd3
    } wst_t;

    // Position of the highest set bit (0 when the value is zero).
    function automatic logic [LOG_W-1:0] top_bit(input addr_t v);
        logic [LOG_W-1:0] r;
        r = '0;
        for (int i = 0; i < int'(ADDR_W); i++) begin
            if (v[i]) r = LOG_W'(i);
        end
        return r;
    endfunction

    // Position of the lowest set bit (0 when the value is zero).
    function automatic logic [LOG_W-1:0] low_bit(input addr_t v);
        logic [LOG_W-1:0] r;
        r = '0;
        for (int i = int'(ADDR_W) - 1; i >= 0; i--) begin
            if (v[i]) r = LOG_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/wsplit_sizer.sv
module wsplit_sizer
    import wsplit_pkg::*;
(
    input  addr_t phys,
    input  addr_t remain,
    output addr_t wsize,
    output addr_t wmask,
    output logic  fits
);

    logic [LOG_W-1:0] fit_log;
    logic [LOG_W-1:0] align_log;
    logic [LOG_W-1:0] pick_log;

    always_comb begin
        fit_log   = top_bit(remain);
        align_log = low_bit(phys);
        pick_log  = ((phys != '0) && (align_log < fit_log)) ? align_log : fit_log;
        wsize     = addr_t'(1) << pick_log;
        wmask     = ~(wsize - addr_t'(1)) & ~FLOOR_BITS;
        fits      = (remain != '0) && (pick_log >= LOG_W'(MIN_LOG2));
    end

    // R2: a chosen window never exceeds what remains and is aligned to the start
    always_comb begin
        if (fits) begin
            p_fit_aligned_r2: assert (((phys & (wsize - addr_t'(1))) == '0) && (wsize <= remain));
        end
    end

endmodule

// File: rtl/wsplit_recfmt.sv
module wsplit_recfmt
    import wsplit_pkg::*;
(
    input  logic             blank,
    input  logic [IDX_W-1:0] slot,
    input  addr_t            phys,
    input  addr_t            bus,
    input  addr_t            wmask,
    input  act_t             action,
    output wrec_t            rec
);

    always_comb begin
        rec.win = slot;
        if (blank) begin
            rec.match  = '0;
            rec.remap  = '0;
            rec.mask   = '0;
            rec.action = '0;
        end else begin
            rec.match  = phys | addr_t'(1);
            rec.remap  = bus;
            rec.mask   = wmask;
            rec.action = action;
        end
    end

endmodule

// File: rtl/wsplit_top.sv
module wsplit_top
    import wsplit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_first,
    input  logic                 req_last,
    input  logic [CNT_W-1:0]     req_start_win,
    input  logic [ADDR_W-1:0]    req_phys,
    input  logic [ADDR_W-1:0]    req_bus,
    input  logic [ADDR_W-1:0]    req_size,
    input  logic [ACT_W-1:0]     req_action,
    output logic                 rec_valid,
    input  logic                 rec_ready,
    output logic [IDX_W-1:0]     rec_win,
    output logic [ADDR_W-1:0]    rec_match,
    output logic [ADDR_W-1:0]    rec_remap,
    output logic [ADDR_W-1:0]    rec_mask,
    output logic [ACT_W-1:0]     rec_action,
    output logic                 done,
    output logic [CNT_W-1:0]     done_win,
    output logic                 done_err
);

    localparam logic [CNT_W-1:0] SLOTS = CNT_W'(NWIN);

    wst_t             st_q;
    addr_t            phys_q, bus_q, size_q;
    act_t             act_q;
    logic             last_q;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] clr_q;
    logic             err_q;

    addr_t wsize, wmask;
    logic  fits;
    wrec_t rec;

    logic split_go, split_end, fail_now, clear_go;

    wsplit_sizer u_sizer (
        .phys   (phys_q),
        .remain (size_q),
        .wsize  (wsize),
        .wmask  (wmask),
        .fits   (fits)
    );

    wsplit_recfmt u_fmt (
        .blank  (st_q == S_CLEAR),
        .slot   ((st_q == S_CLEAR) ? clr_q[IDX_W-1:0] : win_q[IDX_W-1:0]),
        .phys   (phys_q),
        .bus    (bus_q),
        .wmask  (wmask),
        .action (act_q),
        .rec    (rec)
    );

    always_comb begin
        split_go  = (st_q == S_SPLIT) && !err_q && (win_q < SLOTS) && fits;
        split_end = (st_q == S_SPLIT) && !split_go;
        fail_now  = split_end && !err_q && (size_q != '0);
        clear_go  = (st_q == S_CLEAR) && (clr_q < SLOTS);
    end

    assign req_ready  = (st_q == S_IDLE);
    assign rec_valid  = split_go || clear_go;
    assign rec_win    = rec.win;
    assign rec_match  = rec.match;
    assign rec_remap  = rec.remap;
    assign rec_mask   = rec.mask;
    assign rec_action = rec.action;
    assign done       = (st_q == S_FIN);
    assign done_win   = win_q;
    assign done_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            phys_q <= '0;
            bus_q  <= '0;
            size_q <= '0;
            act_q  <= '0;
            last_q <= 1'b0;
            win_q  <= '0;
            clr_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        phys_q <= req_phys;
                        bus_q  <= req_bus;
                        size_q <= req_size;
                        act_q  <= req_action;
                        last_q <= req_last;
                        if (req_first) begin
                            win_q <= req_start_win;
                            err_q <= 1'b0;
                        end
                        st_q <= S_SPLIT;
                    end
                end
                S_SPLIT: begin
                    if (split_go && rec_ready) begin
                        phys_q <= phys_q + wsize;
                        bus_q  <= bus_q + wsize;
                        size_q <= size_q - wsize;
                        win_q  <= win_q + CNT_W'(1);
                    end
                    if (split_end) begin
                        if (fail_now) begin
                            err_q <= 1'b1;
                            win_q <= '0;
                        end
                        clr_q <= fail_now ? '0 : win_q;
                        st_q  <= last_q ? S_CLEAR : S_FIN;
                    end
                end
                S_CLEAR: begin
                    if (clear_go) begin
                        if (rec_ready) clr_q <= clr_q + CNT_W'(1);
                    end else begin
                        st_q <= S_FIN;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R10: a stalled record holds still
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_win) && $stable(rec_match)
            && $stable(rec_remap) && $stable(rec_mask) && $stable(rec_action)));

    // R3: an enabled record's match is aligned to its own mask, floor bits clear
    p_align_r3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_match[0]) |->
            (((rec_match & ~rec_mask) == addr_t'(1)) && ((rec_mask & FLOOR_BITS) == '0)));

    // R4: consecutive split records use consecutive slots
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && rec_match[0]) |=>
            (!rec_valid || !rec_match[0] || (rec_win == IDX_W'($past(rec_win) + 1'b1))));

    // R6: a failed batch reports slot zero
    p_err_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> (done_win == '0));

    // R11: done is a single-cycle pulse with no record beside it
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rec_valid && !req_ready));

endmodule

// File: tb/sim_wsplit_top.sv
module sim_wsplit_top;
    import wsplit_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_first = 1'b0;
    logic             req_last = 1'b0;
    logic [CNT_W-1:0] req_start_win = '0;
    logic [63:0]      req_phys = '0, req_bus = '0, req_size = '0;
    logic [31:0]      req_action = '0;
    logic             rec_valid;
    logic             rec_ready = 1'b0;
    logic [IDX_W-1:0] rec_win;
    logic [63:0]      rec_match, rec_remap, rec_mask;
    logic [31:0]      rec_action;
    logic             done;
    logic [CNT_W-1:0] done_win;
    logic             done_err;

    wsplit_top u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_first(req_first), .req_last(req_last), .req_start_win(req_start_win),
        .req_phys(req_phys), .req_bus(req_bus), .req_size(req_size), .req_action(req_action),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_win(rec_win),
        .rec_match(rec_match), .rec_remap(rec_remap), .rec_mask(rec_mask), .rec_action(rec_action),
        .done(done), .done_win(done_win), .done_err(done_err)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference state and expected record list
    int          m_win = 0;
    bit          m_err = 0;
    int          e_n;
    int          e_win   [16];
    logic [63:0] e_match [16];
    logic [63:0] e_remap [16];
    logic [63:0] e_mask  [16];
    logic [31:0] e_act   [16];
    bit          e_blank [16];
    int          last_got;
    int          first_win;
    logic [15:0] lf = 16'hACE1;

    function automatic logic [63:0] pow_floor(input logic [63:0] v);
        logic [63:0] p;
        p = 64'd1;
        while (p <= (v >> 1)) p = p << 1;
        return p;
    endfunction

    task automatic push(input int w, input logic [63:0] m, input logic [63:0] r,
                        input logic [63:0] k, input logic [31:0] a, input bit b);
        e_win[e_n] = w; e_match[e_n] = m; e_remap[e_n] = r;
        e_mask[e_n] = k; e_act[e_n] = a; e_blank[e_n] = b;
        e_n++;
    endtask

    task automatic build(input logic [63:0] ph, input logic [63:0] bu, input logic [63:0] sz,
                         input logic [31:0] ac, input bit first, input int start, input bit last);
        logic [63:0] ws, lb;
        e_n = 0;
        if (first) begin m_win = start; m_err = 0; end
        if (!m_err) begin
            while (m_win < 8 && sz != 0) begin
                ws = pow_floor(sz);
                if (ph != 0) begin
                    lb = ph & (~ph + 64'd1);
                    if (lb < ws) ws = lb;
                end
                if (ws < 64'h10000) break;
                push(m_win, ph | 64'd1, bu, ~(ws - 64'd1) & ~64'hFFFF, ac, 0);
                ph = ph + ws; bu = bu + ws; sz = sz - ws;
                m_win++;
            end
            if (sz != 0) begin m_err = 1; m_win = 0; end
        end
        if (last) begin
            for (int i = (m_err ? 0 : m_win); i < 8; i++) push(i, 0, 0, 0, 0, 1);
        end
    endtask

    task automatic run(input logic [63:0] ph, input logic [63:0] bu, input logic [63:0] sz,
                       input logic [31:0] ac, input bit first, input int start, input bit last);
        int got;
        bit stall, fin;
        logic [63:0] s_match, s_remap, s_mask;
        logic [31:0] s_act;
        logic [IDX_W-1:0] s_win;
        build(ph, bu, sz, ac, first, start, last);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_first = first; req_last = last;
        req_start_win = CNT_W'(start);
        req_phys = ph; req_bus = bu; req_size = sz; req_action = ac;
        @(negedge clk);
        req_valid = 0;
        got = 0; stall = 0; fin = 0; first_win = -1;
        s_match = 0; s_remap = 0; s_mask = 0; s_act = 0; s_win = 0;
        while (!fin) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rec_ready = lf[0] | lf[1];
            if (stall)
                chk(rec_valid && rec_win == s_win && rec_match == s_match && rec_remap == s_remap
                    && rec_mask == s_mask && rec_action == s_act, "R10", "stalled record held",
                    rec_match, s_match);
            if (rec_valid) begin
                if (rec_ready) begin
                    if (got < e_n) begin
                        if (got == 0) first_win = int'(rec_win);
                        if (e_blank[got]) begin
                            chk(rec_win == IDX_W'(e_win[got]), "R9", "disable slot", 64'(rec_win), 64'(e_win[got]));
                            chk(rec_match == 0 && rec_remap == 0 && rec_mask == 0 && rec_action == 0,
                                "R9", "disable fields zero", rec_match | rec_mask, 0);
                        end else begin
                            chk(rec_win == IDX_W'(e_win[got]), "R4", "split slot", 64'(rec_win), 64'(e_win[got]));
                            chk(rec_mask == e_mask[got], "R2", "window mask", rec_mask, e_mask[got]);
                            chk(rec_match == e_match[got], "R3", "match", rec_match, e_match[got]);
                            chk(rec_remap == e_remap[got], "R4", "remap", rec_remap, e_remap[got]);
                            chk(rec_action == e_act[got], "R3", "action", 64'(rec_action), 64'(e_act[got]));
                        end
                    end else begin
                        chk(0, "R9", "unexpected extra record", 64'(got), 64'(e_n));
                    end
                    got++;
                end
                stall = !rec_ready;
                s_win = rec_win; s_match = rec_match; s_remap = rec_remap;
                s_mask = rec_mask; s_act = rec_action;
            end else begin
                stall = 0;
            end
            if (done) begin
                chk(got == e_n, "R11", "records before done", 64'(got), 64'(e_n));
                chk(done_err == m_err, m_err ? "R6" : "R5", "done_err", 64'(done_err), 64'(m_err));
                chk(done_win == CNT_W'(m_win), m_err ? "R6" : "R5", "done_win", 64'(done_win), 64'(m_win));
                fin = 1;
            end
            @(negedge clk);
        end
        rec_ready = 0;
        chk(!done, "R11", "done one cycle", 64'(done), 0);
        last_got = got;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1", "req_ready after reset", 64'(req_ready), 1);
        chk(rec_valid == 0, "R1", "rec_valid after reset", 64'(rec_valid), 0);
        chk(done == 0 && done_win == 0 && done_err == 0, "R1", "done state after reset",
            64'(done_win), 0);

        // R2 R3 R4 R5 R9: sweep of starts and sizes in 64 KiB units
        for (int k = 0; k < 16; k++) begin
            for (int s = 0; s < 21; s++) begin
                run(64'(k) << 16, 64'h0000_7000_0000_0000 + (64'(k * 5) << 16),
                    64'(s) << 16, 32'(k * 32 + s), 1, 0, 1);
            end
        end

        // R6: start below the floor alignment
        run(64'h8000, 64'h1000_0000, 64'h20000, 32'h4, 1, 0, 1);
        chk(m_err == 1, "R6", "model expects failure", 64'(m_err), 1);
        // R6: tail below the floor
        run(64'h0, 64'h2000_0000, 64'h18000, 32'h4, 1, 0, 1);
        // R6: slots run out
        run(64'h10000, 64'h3000_0000, 64'h70000, 32'h0, 1, 6, 1);
        // R6: huge region exhausting all slots
        run(64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hC, 1, 0, 1);
        // R2: large start alignment, size is the limit
        run(64'h0001_0000_0000_0000, 64'h40_0000_0000, 64'h4000_0000, 32'h4, 1, 0, 1);

        // R8: numbering starts from the supplied slot
        run(64'h40000, 64'hA_0000_0000, 64'h40000, 32'h0, 1, 3, 0);
        chk(first_win == 3, "R8", "first slot from start index", 64'(first_win), 3);
        run(64'h100000, 64'hB_0000_0000, 64'h30000, 32'h0, 0, 0, 0);
        chk(first_win == 4, "R5", "slot carried across regions", 64'(first_win), 4);
        run(64'h200000, 64'hC_0000_0000, 64'h10000, 32'h4, 0, 0, 1);

        // R7: failure in the middle region is sticky
        run(64'h0, 64'hD_0000_0000, 64'h20000, 32'h4, 1, 0, 0);
        run(64'h10000, 64'hE_0000_0000, 64'h14000, 32'h0, 0, 0, 0);
        run(64'h400000, 64'hF_0000_0000, 64'h80000, 32'h0, 0, 0, 0);
        chk(last_got == 0, "R7", "no records while failed", 64'(last_got), 0);
        run(64'h800000, 64'hF_1000_0000, 64'h10000, 32'h0, 0, 0, 1);
        chk(last_got == 8, "R9", "full disable sweep after failure", 64'(last_got), 8);

        // R8: a new batch clears the failure
        run(64'h20000, 64'h5_0000_0000, 64'h20000, 32'h4, 1, 0, 1);
        chk(first_win == 0 && m_err == 0, "R8", "failure cleared by restart", 64'(first_win), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule